// File: doc/BRIEF.md
# Oversampling serial receiver with per-character status queue

This block receives asynchronous serial characters on a single input line. The line is resynchronised to the system clock. It is then examined once per pulse of a tick enable that runs at sixteen times the bit rate. A falling edge starts a frame. Each bit, including the start bit, is settled by a two-of-three vote taken from the middle samples of its bit period. The data length is selectable from five to eight bits. An optional parity bit can be checked as even or odd, and the first stop bit is checked for a framing fault.

Every finished character goes into a two-entry queue together with its own parity and framing status. The flags at the output always describe the character currently at the head of the queue. A reader pulses a read strobe to pop the head, and keeps doing so while the available flag stays high. If a character completes while the queue is full, that character is discarded and an overrun flag is raised. Dropping the receive enable abandons any frame in progress on the same edge, empties the queue and releases the line.

Top module: `uart_rx_fifo`

## Requirements
- R1: While reset is asserted and right after it is released, `avail_o`, `ovr_o`, `perr_o` and `ferr_o` are 0 and `data_o` is 0.
- R2: A frame is a low start bit, then data bits least-significant first, then an optional parity bit, then a high stop bit. Each bit lasts 16 ticks, and its received character appears on `data_o` with `avail_o` high.
- R3: `len_sel_i` selects the data length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Data bits above the selected length read as 0 on `data_o`.
- R4: Each bit value is the majority of the samples taken at ticks 8, 9 and 10 of that bit (the detecting tick counts as tick 0). A single deviating sample among these three does not change the value.
- R5: If the start bit votes high at its middle, the frame is abandoned and no character is stored.
- R6: With `par_on_i` high when the frame starts, a parity bit follows the data. `par_odd_i`=0 expects even parity over data plus parity bit, and 1 expects odd parity. A mismatch sets `perr_o` for that character. With parity off, `perr_o` stays 0.
- R7: A stop bit that votes low still stores the character, with `ferr_o` set for it.
- R8: `perr_o` and `ferr_o` belong to the head character. They stay stable until that character is popped, and then show the next character's own status.
- R9: The queue holds two characters. A character that completes while the queue is full and no pop occurs is dropped and sets `ovr_o`, which clears on the next pop.
- R10: A pop and a completing character in the same clock cycle with the queue full are both honoured: the head leaves and the new character is kept.
- R11: Clearing `rx_on_i` empties the queue and clears `ovr_o` by the next edge, aborts any frame in progress, and drives `line_claim_o` low.
- R12: `avail_o` stays high while unread characters remain. A read strobe with the queue empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Sampling enable at 16x the bit rate |
| rx_on_i | input | 1 | Receiver enable |
| par_on_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| len_sel_i | input | 2 | Data length select (5 + value) |
| rd_i | input | 1 | Pop strobe for the head character |
| data_o | output | 8 | Head character |
| avail_o | output | 1 | Queue not empty |
| perr_o | output | 1 | Parity fault of head character |
| ferr_o | output | 1 | Framing fault of head character |
| ovr_o | output | 1 | A character was dropped on a full queue |
| line_claim_o | output | 1 | Receiver owns the serial line |

## Verification
Two things can happen in the same clock cycle: the stop-bit decision that pushes a character, and a pop from the reader. With the queue already holding two characters, the bench counts ticks inside the third frame and raises the read strobe in exactly the tick cycle of the stop bit's deciding sample. The outcome is judged by reading out the queue afterwards. The second and third characters must come out in order, and no overrun may be flagged. A second run without the pop at that point must instead lose the third character and raise the overrun flag.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } urx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } urx_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       par_on_i,
  input  logic       par_odd_i,
  input  logic [1:0] len_sel_i,
  output logic       push_o,
  output urx_entry_t entry_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] SMP0 = CW'(OSR / 2);
  localparam logic [CW-1:0] SMP1 = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] SMP2 = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  urx_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bidx_q, bidx_n;
  logic [1:0]    vote_q, vote_n;
  logic [7:0]    shreg_q, shreg_n;
  logic          perr_q, perr_n;
  logic          pon_q, pon_n;
  logic          podd_q, podd_n;
  logic [2:0]    len_q, len_n;
  logic          maj, decide, at_last;

  assign maj     = (vote_q[0] & vote_q[1]) | (vote_q[0] & line_i) | (vote_q[1] & line_i);
  assign decide  = tick_i && (cnt_q == SMP2);
  assign at_last = (cnt_q == LAST);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bidx_n  = bidx_q;
    vote_n  = vote_q;
    shreg_n = shreg_q;
    perr_n  = perr_q;
    pon_n   = pon_q;
    podd_n  = podd_q;
    len_n   = len_q;
    if (!en_i) begin
      state_n = S_IDLE;
      cnt_n   = '0;
    end else if (tick_i) begin
      if (state_q == S_IDLE) begin
        if (!line_i) begin
          state_n = S_START;
          cnt_n   = CW'(1);
          shreg_n = '0;
          perr_n  = 1'b0;
          pon_n   = par_on_i;
          podd_n  = par_odd_i;
          len_n   = 3'd4 + {1'b0, len_sel_i};
        end
      end else begin
        cnt_n = at_last ? '0 : cnt_q + 1'b1;
        if (cnt_q == SMP0) vote_n[0] = line_i;
        if (cnt_q == SMP1) vote_n[1] = line_i;
        case (state_q)
          S_START: begin
            if (decide && maj) state_n = S_IDLE;
            else if (at_last) begin
              state_n = S_DATA;
              bidx_n  = '0;
            end
          end
          S_DATA: begin
            if (decide) shreg_n[bidx_q] = maj;
            if (at_last) begin
              if (bidx_q == len_q) state_n = pon_q ? S_PAR : S_STOP;
              else                 bidx_n  = bidx_q + 1'b1;
            end
          end
          S_PAR: begin
            if (decide) perr_n = (^shreg_q) ^ maj ^ podd_q;
            if (at_last) state_n = S_STOP;
          end
          S_STOP: begin
            if (decide) state_n = S_IDLE;
          end
          default: state_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      vote_q  <= '1;
      shreg_q <= '0;
      perr_q  <= 1'b0;
      pon_q   <= 1'b0;
      podd_q  <= 1'b0;
      len_q   <= 3'd7;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      vote_q  <= vote_n;
      shreg_q <= shreg_n;
      perr_q  <= perr_n;
      pon_q   <= pon_n;
      podd_q  <= podd_n;
      len_q   <= len_n;
    end
  end

  assign push_o       = en_i && decide && (state_q == S_STOP);
  assign entry_o.data = shreg_q;
  assign entry_o.perr = pon_q & perr_q;
  assign entry_o.ferr = ~maj;
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
  import urx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  urx_entry_t                 wdata_i,
  input  logic                       pop_i,
  output urx_entry_t                 head_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       ovr_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  urx_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovr_q, ovr_n;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i && (cnt_q != '0);
  assign push_ok = push_i && ((cnt_q != FULL) || pop_ok);

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    ovr_n = ovr_q;
    if (flush_i) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
      ovr_n = 1'b0;
    end else begin
      if (push_ok) wr_n = (wr_q == PMAX) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_n = (rd_q == PMAX) ? '0 : rd_q + 1'b1;
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
      if (pop_ok) ovr_n = 1'b0;
      if (push_i && !push_ok) ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovr_q <= ovr_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && !flush_i && (wr_q == AW'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import urx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int DEPTH      = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  input  logic       tick16_i,
  input  logic       rx_on_i,
  input  logic       par_on_i,
  input  logic       par_odd_i,
  input  logic [1:0] len_sel_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       avail_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       ovr_o,
  output logic       line_claim_o
);
  localparam int OCW = $clog2(DEPTH + 1);

  logic [1:0]     rst_sh_q;
  logic           rst_s_n;
  logic           line_s;
  logic           push;
  urx_entry_t     wentry, head;
  logic [OCW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  urx_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d_i(rxd_i), .q_o(line_s)
  );

  urx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_s_n), .en_i(rx_on_i), .tick_i(tick16_i),
    .line_i(line_s), .par_on_i(par_on_i), .par_odd_i(par_odd_i),
    .len_sel_i(len_sel_i), .push_o(push), .entry_o(wentry)
  );

  urx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .flush_i(!rx_on_i), .push_i(push),
    .wdata_i(wentry), .pop_i(rd_i), .head_o(head), .cnt_o(occ),
    .ovr_o(ovr_o)
  );

  assign avail_o      = (occ != '0);
  assign data_o       = avail_o ? head.data : 8'h00;
  assign perr_o       = avail_o & head.perr;
  assign ferr_o       = avail_o & head.ferr;
  assign line_claim_o = rx_on_i;
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
  parameter int DEPTH = 2,
  parameter int OCW   = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_on_i,
  input logic           rd_i,
  input logic [7:0]     data_o,
  input logic           avail_o,
  input logic           perr_o,
  input logic           ferr_o,
  input logic           ovr_o,
  input logic [OCW-1:0] occ
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!avail_o && !ovr_o)
        else $error("reset state violated");
    end
  end

  assert_off_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on_i |=> (!avail_o && !ovr_o));

  assert_hold_avail_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_o && !rd_i && rx_on_i) |=> avail_o);

  assert_head_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_o && !rd_i && rx_on_i) |=> ($stable(data_o) && $stable(perr_o) && $stable(ferr_o)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCW'(DEPTH));

  assert_ovr_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> ($past(occ) == OCW'(DEPTH)));

  assert_flags_need_char_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o || ferr_o) |-> avail_o);
endmodule

bind uart_rx_fifo urx_chk #(.DEPTH(DEPTH), .OCW(OCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_on_i(rx_on_i), .rd_i(rd_i),
  .data_o(data_o), .avail_o(avail_o), .perr_o(perr_o),
  .ferr_o(ferr_o), .ovr_o(ovr_o), .occ(occ)
);

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd_i, tick16_i, rx_on_i, par_on_i, par_odd_i, rd_i;
  logic [1:0] len_sel_i;
  logic [7:0] data_o;
  logic       avail_o, perr_o, ferr_o, ovr_o, line_claim_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .tick16_i(tick16_i),
    .rx_on_i(rx_on_i), .par_on_i(par_on_i), .par_odd_i(par_odd_i),
    .len_sel_i(len_sel_i), .rd_i(rd_i), .data_o(data_o),
    .avail_o(avail_o), .perr_o(perr_o), .ferr_o(ferr_o),
    .ovr_o(ovr_o), .line_claim_o(line_claim_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_step(input bit pop);
    repeat (3) @(negedge clk);
    tick16_i = 1'b1;
    rd_i     = pop;
    @(negedge clk);
    tick16_i = 1'b0;
    rd_i     = 1'b0;
  endtask

  task automatic send_bit(input bit v, input int gpos, input int popat);
    for (int j = 0; j < 16; j++) begin
      rxd_i = (j == gpos) ? ~v : v;
      tick_step(j == popat);
    end
  endtask

  task automatic idle_ticks(input int n);
    rxd_i = 1'b1;
    for (int j = 0; j < n; j++) tick_step(1'b0);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit podd, input bit badp, input bit stopv,
                            input int gbit, input int gpos, input bit pop_at_stop);
    bit p;
    par_on_i  = pen;
    par_odd_i = podd;
    len_sel_i = 2'(nb - 5);
    send_bit(1'b0, -1, -1);
    for (int i = 0; i < nb; i++) send_bit(d[i], (i == gbit) ? gpos : -1, -1);
    if (pen) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      p = p ^ podd ^ badp;
      send_bit(p, -1, -1);
    end
    send_bit(stopv, -1, pop_at_stop ? 10 : -1);
    idle_ticks(2);
  endtask

  task automatic expect_char(input logic [7:0] d, input bit pe, input bit fe, input string tag);
    @(negedge clk);
    check(avail_o == 1'b1, {tag, " avail"}, avail_o, 1);
    check(data_o == d, {tag, " data"}, data_o, d);
    check(perr_o == pe, {tag, " perr"}, perr_o, pe);
    check(ferr_o == fe, {tag, " ferr"}, ferr_o, fe);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    check(avail_o == 1'b0, {tag, " empty"}, avail_o, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rxd_i = 1'b1; tick16_i = 1'b0; rx_on_i = 1'b1;
    par_on_i = 1'b0; par_odd_i = 1'b0; len_sel_i = 2'd3; rd_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!avail_o && !ovr_o && !perr_o && !ferr_o, "R1 during reset", {avail_o, ovr_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(data_o == 8'h00 && !avail_o, "R1 after reset", data_o, 0);
    check(line_claim_o == 1'b1, "R11 claim when on", line_claim_o, 1);
  endtask

  task automatic t_basic;
    send_frame(8'hA5, 8, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'hA5, 0, 0, "R2 8N1 A5");
    send_frame(8'h3C, 8, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'h3C, 0, 0, "R2 8N1 3C");
    expect_empty("R12 after read");
  endtask

  task automatic t_lengths;
    send_frame(8'h15, 5, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'h15, 0, 0, "R3 len5");
    send_frame(8'hFF, 6, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'h3F, 0, 0, "R3 len6");
    send_frame(8'h4B, 7, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'h4B, 0, 0, "R3 len7");
  endtask

  task automatic t_noise;
    send_frame(8'h5A, 8, 0, 0, 0, 1, 2, 9, 0);
    expect_char(8'h5A, 0, 0, "R4 glitch sample 9");
    send_frame(8'h81, 8, 0, 0, 0, 1, 0, 8, 0);
    expect_char(8'h81, 0, 0, "R4 glitch sample 8");
    send_frame(8'h7E, 8, 0, 0, 0, 1, 5, 10, 0);
    expect_char(8'h7E, 0, 0, "R4 glitch sample 10");
  endtask

  task automatic t_start_glitch;
    rxd_i = 1'b0;
    for (int j = 0; j < 7; j++) tick_step(1'b0);
    idle_ticks(30);
    expect_empty("R5 short start");
  endtask

  task automatic t_parity;
    send_frame(8'h37, 8, 1, 0, 0, 1, -1, -1, 0);
    expect_char(8'h37, 0, 0, "R6 even ok");
    send_frame(8'h37, 8, 1, 0, 1, 1, -1, -1, 0);
    expect_char(8'h37, 1, 0, "R6 even bad");
    send_frame(8'h12, 7, 1, 1, 0, 1, -1, -1, 0);
    expect_char(8'h12, 0, 0, "R6 odd ok");
    send_frame(8'h12, 7, 1, 1, 1, 1, -1, -1, 0);
    par_on_i = 1'b0;
    expect_char(8'h12, 1, 0, "R6 odd bad kept after parity off");
  endtask

  task automatic t_frame_err;
    send_frame(8'hC3, 8, 0, 0, 0, 0, -1, -1, 0);
    idle_ticks(24);
    expect_char(8'hC3, 0, 1, "R7 low stop");
    expect_empty("R7 no extra char");
  endtask

  task automatic t_travel;
    send_frame(8'h0F, 8, 1, 0, 1, 1, -1, -1, 0);
    send_frame(8'hF1, 8, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'h0F, 1, 0, "R8 head status");
    expect_char(8'hF1, 0, 0, "R8 next status");
  endtask

  task automatic t_overrun;
    send_frame(8'h11, 8, 0, 0, 0, 1, -1, -1, 0);
    send_frame(8'h22, 8, 0, 0, 0, 1, -1, -1, 0);
    send_frame(8'h33, 8, 0, 0, 0, 1, -1, -1, 0);
    @(negedge clk);
    check(ovr_o == 1'b1, "R9 overrun set", ovr_o, 1);
    expect_char(8'h11, 0, 0, "R9 first kept");
    check(ovr_o == 1'b0, "R9 overrun cleared by pop", ovr_o, 0);
    expect_char(8'h22, 0, 0, "R9 second kept");
    expect_empty("R9 third dropped");
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    expect_empty("R12 read on empty");
  endtask

  task automatic t_same_cycle;
    send_frame(8'h44, 8, 0, 0, 0, 1, -1, -1, 0);
    send_frame(8'h55, 8, 0, 0, 0, 1, -1, -1, 0);
    send_frame(8'h66, 8, 0, 0, 0, 1, -1, -1, 1);
    @(negedge clk);
    check(ovr_o == 1'b0, "R10 no overrun", ovr_o, 0);
    expect_char(8'h55, 0, 0, "R10 second");
    expect_char(8'h66, 0, 0, "R10 third kept");
    expect_empty("R10 drained");
  endtask

  task automatic t_disable;
    send_frame(8'h99, 8, 0, 0, 0, 1, -1, -1, 0);
    send_frame(8'hAA, 8, 0, 0, 0, 1, -1, -1, 0);
    send_frame(8'hBB, 8, 0, 0, 0, 1, -1, -1, 0);
    par_on_i = 1'b0;
    len_sel_i = 2'd3;
    send_bit(1'b0, -1, -1);
    send_bit(1'b1, -1, -1);
    send_bit(1'b0, -1, -1);
    rx_on_i = 1'b0;
    @(negedge clk);
    check(avail_o == 1'b0, "R11 flushed", avail_o, 0);
    check(ovr_o == 1'b0, "R11 overrun cleared", ovr_o, 0);
    check(line_claim_o == 1'b0, "R11 released", line_claim_o, 0);
    for (int i = 0; i < 6; i++) send_bit(1'b1, -1, -1);
    rx_on_i = 1'b1;
    idle_ticks(20);
    expect_empty("R11 aborted frame gone");
    send_frame(8'h6C, 8, 0, 0, 0, 1, -1, -1, 0);
    expect_char(8'h6C, 0, 0, "R11 works after re-enable");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lengths();
    t_noise();
    t_start_glitch();
    t_parity();
    t_frame_err();
    t_travel();
    t_overrun();
    t_same_cycle();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule